// File: doc/BRIEF.md
# 100Base-X Receive Nibble Framer

This block sits behind symbol alignment in a 100Base-X receive path. Each receive clock it takes one aligned 5-bit code-group and produces a nibble-wide receive interface: a 4-bit data bus, a data-valid strobe and an error strobe. All outputs are registered on the receive clock. The block looks for the start-of-stream pair (J followed by K) and opens a frame when it finds one. While the frame is open it translates data code-groups to nibbles with the 4B/5B table. The frame closes on the end-of-stream pair (T followed by R), when the link-status input reports failure, or when the signal-detect input drops.

The two start delimiter code-groups are presented on the bus as the preamble nibble 0101. The end delimiter code-groups are swallowed and never appear as data. A code-group inside a frame that is neither a data code nor the closing pair raises the error strobe for that one cycle. The frame then carries on.

The framer holds one code-group of look-ahead, so it can tell J from a false start and T from a stray T. The nibble for the code-group sampled at clock edge n therefore appears at the outputs after edge n+1.

Top module: `fx_rx_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rx_dv`, `rx_err` and `rx_nib` are all 0 after that edge, and any open frame is abandoned.
- R2: When J (11000) is sampled at one edge and K (10001) at the next, with `link_ok` and `sig_det` both high, `rx_dv` rises after the K edge with `rx_nib` = 0101 (for J). On the following cycle `rx_nib` is again 0101 (for K).
- R3: Inside a frame, the nibble for a data code-group sampled at edge n appears on `rx_nib` after edge n+1, with `rx_err` low. The 4B/5B table applies: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. Bit 0 of `rx_nib` is the least significant bit of the nibble.
- R4: T (01101) sampled at one edge and R (00111) at the next close the frame: `rx_dv` is low after the R edge. Neither T nor R is presented as a nibble.
- R5: `link_ok` low at any edge makes `rx_dv` low after that edge. A frame closed this way stays closed until a new J/K pair arrives. A J/K pair seen while `link_ok` is low opens no frame.
- R6: `sig_det` low at any edge makes `rx_dv` low after that edge, with the same closing behaviour as R5.
- R7: Inside a frame, each code-group that is not a data code-group (for example 00000, the idle 11111, or J/K after the start pair) gives exactly one cycle with `rx_err` high and `rx_nib` = 0000 while `rx_dv` stays high.
- R8: `rx_err` is never high while `rx_dv` is low. Invalid code-groups outside a frame produce no output activity.
- R9: A J that is not immediately followed by K is a false start: `rx_dv` stays low.
- R10: A T that is not immediately followed by R is an invalid code-group under R7, and the frame stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one code-group per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cg_in | input | 5 | Aligned received code-group, bit 4 is first on the line |
| link_ok | input | 1 | High while the link monitor reports a good link |
| sig_det | input | 1 | High while signal energy is detected |
| rx_nib | output | 4 | Decoded receive nibble, bit 0 is the LSB |
| rx_dv | output | 1 | Receive data valid, high for the length of a frame |
| rx_err | output | 1 | One-cycle error strobe for an invalid code-group in a frame |

## Verification
The hardest situations to reach are those where the one-code-group look-ahead has to decide between two readings. Examples are a J followed by something other than K, a T followed by something other than R, and a T immediately followed by another T and then R. A drop of the link or of the signal in the very cycle after the start pair is also hard to reach. The bench reaches these by driving handcrafted code-group sequences one cycle at a time, with link and signal-detect values chosen per cycle. For each cycle it queues the output it expects after the next edge, so each of these corners is checked on the exact cycle where the two readings diverge.

// File: rtl/fx_rx_pkg.sv
// Package: shared code-group constants and the framer state type.
// Assumes 5-bit code-groups and 4-bit nibbles as in 100Base-X.
package fx_rx_pkg;
    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'b0101;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SSD2  = 2'd1,
        FR_DATA  = 2'd2
    } fr_state_e;
endpackage

// File: rtl/fx_cg_decoder.sv
// Module: fx_cg_decoder
// Translates one 5-bit code-group to a nibble with the 4B/5B data table.
// Purely combinational. Control code-groups and unused codes report
// data_ok = 0 and nibble 0. Assumes CG_W = 5 and NIB_W = 4.
module fx_cg_decoder
    import fx_rx_pkg::*;
#(
    parameter int CW = CG_W,
    parameter int NW = NIB_W
) (
    input  logic [CW-1:0] cg,
    output logic [NW-1:0] nib,
    output logic          data_ok
);
    // Table lookup from code-group to nibble
    always_comb begin
        data_ok = 1'b1;
        nib     = '0;
        unique case (cg)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            default: begin
                data_ok = 1'b0;
                nib     = '0;
            end
        endcase
    end
endmodule

// File: rtl/fx_delim_detect.sv
// Module: fx_delim_detect
// Holds the previous code-group as one-cycle look-ahead. Flags the
// start pair (J then K) and the end pair (T then R) when the previous
// and the current code-group form them. Assumes one code-group per clock.
module fx_delim_detect
    import fx_rx_pkg::*;
#(
    parameter int CW = CG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cg_cur,
    output logic [CW-1:0] cg_prev,
    output logic          start_pair,
    output logic          end_pair
);
    // Look-ahead register, reset to the idle code so no pair matches
    always_ff @(posedge clk) begin
        if (!rst_n) cg_prev <= CG_IDLE;
        else        cg_prev <= cg_cur;
    end

    // Pair matching on the previous and the current code-group
    always_comb begin
        start_pair = (cg_prev == CG_J) && (cg_cur == CG_K);
        end_pair   = (cg_prev == CG_T) && (cg_cur == CG_R);
    end

    // R4 R9: the two pairs can never be seen at the same time
    pairs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pair, end_pair}));
endmodule

// File: rtl/fx_frame_fsm.sv
// Module: fx_frame_fsm
// Frame state machine with registered outputs. It presents the start
// pair as two preamble nibbles, then decoded data, and closes on the
// end pair or on loss of link or signal. Assumes the decoder works on
// the look-ahead code-group, the one being presented this cycle.
module fx_frame_fsm
    import fx_rx_pkg::*;
#(
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          start_pair,
    input  logic          end_pair,
    input  logic [NW-1:0] dec_nib,
    input  logic          dec_ok,
    output logic [NW-1:0] nib_q,
    output logic          dv_q,
    output logic          err_q
);
    fr_state_e state_q, state_d;
    logic [NW-1:0] nib_d;
    logic dv_d, err_d;

    // Next-state and next-output decision
    always_comb begin
        state_d = state_q;
        nib_d   = '0;
        dv_d    = 1'b0;
        err_d   = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                if (start_pair && link_up) begin
                    state_d = FR_SSD2;
                    dv_d    = 1'b1;
                    nib_d   = NIB_PREAMBLE;
                end
            end
            FR_SSD2: begin
                if (!link_up) begin
                    state_d = FR_IDLE;
                end else begin
                    state_d = FR_DATA;
                    dv_d    = 1'b1;
                    nib_d   = NIB_PREAMBLE;
                end
            end
            FR_DATA: begin
                if (!link_up || end_pair) begin
                    state_d = FR_IDLE;
                end else begin
                    dv_d  = 1'b1;
                    err_d = !dec_ok;
                    nib_d = dec_ok ? dec_nib : '0;
                end
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // State and output registers, cleared by the synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            nib_q   <= '0;
            dv_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            nib_q   <= nib_d;
            dv_q    <= dv_d;
            err_q   <= err_d;
        end
    end

    // R8
    err_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> dv_q);

    // R2
    first_nibble_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_q) |-> (nib_q == NIB_PREAMBLE));

    // R9
    rise_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_q) |-> $past(start_pair));

    // R5 R6
    link_loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !dv_q);

    // R4
    end_pair_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pair && dv_q && !$rose(dv_q)) |=> !dv_q);

    // R7
    err_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (nib_q == '0));
endmodule

// File: rtl/fx_rx_framer.sv
// Module: fx_rx_framer (top)
// 100Base-X receive framer. Aligned code-groups in, nibble, data-valid
// and error strobe out. Assumes one aligned code-group per receive clock
// and a synchronous active-low reset.
module fx_rx_framer
    import fx_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CG_W-1:0]  cg_in,
    input  logic             link_ok,
    input  logic             sig_det,
    output logic [NIB_W-1:0] rx_nib,
    output logic             rx_dv,
    output logic             rx_err
);
    logic [CG_W-1:0]  cg_prev;
    logic             start_pair, end_pair;
    logic [NIB_W-1:0] dec_nib;
    logic             dec_ok;
    logic             link_up;

    // Link is usable only with both link status and signal present
    always_comb link_up = link_ok && sig_det;

    fx_delim_detect #(.CW(CG_W)) u_delim (
        .clk        (clk),
        .rst_n      (rst_n),
        .cg_cur     (cg_in),
        .cg_prev    (cg_prev),
        .start_pair (start_pair),
        .end_pair   (end_pair)
    );

    fx_cg_decoder #(.CW(CG_W), .NW(NIB_W)) u_dec (
        .cg      (cg_prev),
        .nib     (dec_nib),
        .data_ok (dec_ok)
    );

    fx_frame_fsm #(.NW(NIB_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_up    (link_up),
        .start_pair (start_pair),
        .end_pair   (end_pair),
        .dec_nib    (dec_nib),
        .dec_ok     (dec_ok),
        .nib_q      (rx_nib),
        .dv_q       (rx_dv),
        .err_q      (rx_err)
    );
endmodule

// File: tb/fx_rx_framer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the output expected after each
// edge, and the monitor pops and compares one entry per edge.
module fx_rx_framer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cg_in = 5'b11111;
    logic       link_ok = 1'b0;
    logic       sig_det = 1'b0;
    logic [3:0] rx_nib;
    logic       rx_dv, rx_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic       dv;
        logic       err;
        logic [3:0] nib;
        string      tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111, H = 5'b00100;

    fx_rx_framer uut (
        .clk(clk), .rst_n(rst_n), .cg_in(cg_in), .link_ok(link_ok),
        .sig_det(sig_det), .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_err(rx_err)
    );

    always #2 clk = ~clk;

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
            4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
            4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
            4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
            4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    // Driver step: drive inputs at the falling edge, queue the expected result
    task automatic step(input logic [4:0] cg, input logic lk, input logic sd,
                        input logic rs, input logic edv, input logic eerr,
                        input logic [3:0] enib, input string tag);
        @(negedge clk);
        cg_in = cg; link_ok = lk; sig_det = sd; rst_n = rs;
        sb.push_back('{dv: edv, err: eerr, nib: enib, tag: tag});
    endtask

    task automatic go(input logic [4:0] cg, input logic edv, input logic eerr,
                      input logic [3:0] enib, input string tag);
        step(cg, 1'b1, 1'b1, 1'b1, edv, eerr, enib, tag);
    endtask

    // A full clean frame carrying the nibbles in pay[]
    task automatic send_frame(input logic [3:0] pay[$], input string tag);
        logic [3:0] last;
        go(J, 0, 0, 4'h0, tag);
        go(K, 1, 0, 4'h5, "R2");
        last = 4'h5;
        foreach (pay[i]) begin
            go(enc(pay[i]), 1, 0, last, tag);
            last = pay[i];
        end
        go(T, 1, 0, last, tag);
        go(R, 0, 0, 4'h0, "R4");
        go(I, 0, 0, 4'h0, "R4");
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rx_dv !== e.dv || rx_err !== e.err || rx_nib !== e.nib) begin
                errors++;
                $display("FAIL %s: got dv=%b err=%b nib=%h expected dv=%b err=%b nib=%h",
                         e.tag, rx_dv, rx_err, rx_nib, e.dv, e.err, e.nib);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] pay[$];
        // R1: reset state with busy inputs
        step(J, 1, 1, 0, 0, 0, 4'h0, "R1");
        step(K, 1, 1, 0, 0, 0, 4'h0, "R1");
        step(I, 1, 1, 0, 0, 0, 4'h0, "R1");
        go(I, 0, 0, 4'h0, "R1");

        // R2 R3 R4: every data nibble in one frame
        pay = {};
        for (int n = 0; n < 16; n++) pay.push_back(4'(n));
        send_frame(pay, "R3");

        // R8: invalid codes outside a frame
        go(5'b00000, 0, 0, 4'h0, "R8");
        go(H, 0, 0, 4'h0, "R8");
        go(T, 0, 0, 4'h0, "R8");
        go(R, 0, 0, 4'h0, "R8");
        go(K, 0, 0, 4'h0, "R8");

        // R9: false start, J then idle then K
        go(J, 0, 0, 4'h0, "R9");
        go(I, 0, 0, 4'h0, "R9");
        go(K, 0, 0, 4'h0, "R9");
        go(J, 0, 0, 4'h0, "R9");
        go(J, 0, 0, 4'h0, "R9");
        go(5'b10110, 0, 0, 4'h0, "R9");

        // R7: invalid code-groups inside a frame
        go(J, 0, 0, 4'h0, "R7");
        go(K, 1, 0, 4'h5, "R2");
        go(enc(4'h3), 1, 0, 4'h5, "R7");
        go(5'b00000, 1, 0, 4'h3, "R7");
        go(enc(4'hA), 1, 1, 4'h0, "R7");
        go(H, 1, 0, 4'hA, "R7");
        go(J, 1, 1, 4'h0, "R7");
        go(T, 1, 1, 4'h0, "R7");
        go(R, 0, 0, 4'h0, "R4");
        go(I, 0, 0, 4'h0, "R4");

        // R10: stray T, then T T R closing
        go(J, 0, 0, 4'h0, "R10");
        go(K, 1, 0, 4'h5, "R2");
        go(T, 1, 0, 4'h5, "R10");
        go(enc(4'h7), 1, 1, 4'h0, "R10");
        go(T, 1, 0, 4'h7, "R10");
        go(T, 1, 1, 4'h0, "R10");
        go(R, 0, 0, 4'h0, "R10");
        go(I, 0, 0, 4'h0, "R10");

        // R5: link failure mid-frame, later data not presented
        go(J, 0, 0, 4'h0, "R5");
        go(K, 1, 0, 4'h5, "R5");
        go(enc(4'h9), 1, 0, 4'h5, "R5");
        step(enc(4'h2), 0, 1, 1, 0, 0, 4'h0, "R5");
        go(enc(4'h4), 0, 0, 4'h0, "R5");
        go(T, 0, 0, 4'h0, "R5");
        go(R, 0, 0, 4'h0, "R5");
        // R5: start pair while link is down
        step(J, 0, 1, 1, 0, 0, 4'h0, "R5");
        step(K, 0, 1, 1, 0, 0, 4'h0, "R5");
        go(enc(4'h1), 0, 0, 4'h0, "R5");

        // R6: signal loss right after the start pair
        go(J, 0, 0, 4'h0, "R6");
        go(K, 1, 0, 4'h5, "R6");
        step(enc(4'h6), 1, 0, 1, 0, 0, 4'h0, "R6");
        go(enc(4'h6), 0, 0, 4'h0, "R6");
        go(I, 0, 0, 4'h0, "R6");

        // R1: reset in the middle of a frame
        go(J, 0, 0, 4'h0, "R1");
        go(K, 1, 0, 4'h5, "R1");
        step(enc(4'hC), 1, 1, 0, 0, 0, 4'h0, "R1");
        go(enc(4'hD), 0, 0, 4'h0, "R1");
        go(I, 0, 0, 4'h0, "R1");

        // R3: back-to-back frames
        pay = {4'hE, 4'h1};
        send_frame(pay, "R3");
        pay = {4'h8};
        send_frame(pay, "R3");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule